// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block performs SIMD-style addition and subtraction on a 32-bit word that is split into independent lanes. A two-bit mode selects the lane split: four unsigned bytes, two signed halfwords, or one signed word. A four-bit operation code selects wrapping add or subtract, saturating add or subtract, saturating absolute value, or a halving add or subtract, with or without rounding.

Every lane is computed on its own, with no carry between lanes. Any lane that overflows in an accepted operation sets one sticky bit in a 32-bit control image. That bit stays set until reset. The packed result and the updated control image both appear one clock after the input strobe. A processor pipeline issues one operation per strobe and reads the control image to find out whether any earlier operation lost precision.

Top module: `pk_addsub_unit`

## Requirements
- R1: Mode 0 treats the operands as four unsigned 8-bit lanes, with lane i at bits [8i+7:8i]. Mode 1 treats them as two signed 16-bit lanes, with lane i at bits [16i+15:16i]. Mode 2 treats them as one signed 32-bit lane. Mode 3 is reserved: it gives a zero result and never sets the flag.
- R2: Operation code 0 is a wrapping add and code 1 is a wrapping subtract. The lane result is the sum or difference modulo the lane width. The flag is set on signed overflow in signed lanes, and on a carry-out (add) or a borrow (subtract) in unsigned lanes.
- R3: Operation codes 2 and 3 are the saturating add and saturating subtract. When a signed lane overflows, the result is clamped to the lane maximum if operand A is non-negative, and to the lane minimum if operand A is negative. The flag is set.
- R4: With the saturating codes in unsigned lanes, an add that carries out gives all ones and a subtract that borrows gives zero. Both set the flag.
- R5: Operation code 4 is a saturating absolute value of operand A. In every mode, including the byte mode, A is read as a signed two's-complement number. The most negative value returns the most positive value and sets the flag. Every other value returns its magnitude without a flag.
- R6: Operation codes 5 and 6 are halving add, and codes 7 and 8 are halving subtract. Codes 6 and 8 add 1 to the result before the halving. The sum or difference is formed exactly, with extended width (sign-extended in signed lanes, zero-extended in unsigned lanes). Bits [W:1] of that exact value are returned. These codes never set the flag.
- R7: An operation is accepted on a clock edge where in_valid is 1. The result and the control image update at that edge, and out_valid is 1 for that one following cycle. Without in_valid, the result and the control image hold.
- R8: Bit 20 of the control image is set when any lane of an accepted operation overflows, and it stays set. Every other bit of the control image is 0.
- R9: Operation codes 9 to 15 give a zero result and never set the flag.
- R10: Reset clears the result, the control image and out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Lane split select |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| out_valid | output | 1 | Result-updated pulse |
| result | output | 32 | Registered packed result |
| ctl_img | output | 32 | Control image; bit 20 is the sticky overflow flag |

## Verification
Two functions can act in the same cycle: the arithmetic of an accepted operation, and the update of the sticky flag. They interact when a lane overflows in an operation that is flagged, or is accepted but must not flag. The bench resets the unit and then runs every halving code, the reserved mode and the unused codes first, using saturating-edge operands such as maximum plus one. It judges the result and that the control image is still zero after each of them. After that, the flagging operations run, and the model's sticky bit is compared with the control image on every operation, alongside the packed result.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic [1:0] {
    LM_U8  = 2'd0,
    LM_S16 = 2'd1,
    LM_S32 = 2'd2,
    LM_RSV = 2'd3
  } lane_mode_e;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDS  = 4'd2,
    OP_SUBS  = 4'd3,
    OP_ABS   = 4'd4,
    OP_HADD  = 4'd5,
    OP_HADDR = 4'd6,
    OP_HSUB  = 4'd7,
    OP_HSUBR = 4'd8
  } pk_op_e;

  function automatic logic op_is_halving(input logic [3:0] code);
    return (code >= 4'd5) && (code <= 4'd8);
  endfunction

  function automatic logic op_is_known(input logic [3:0] code);
    return code <= 4'd8;
  endfunction

endpackage

// File: rtl/pk_lane.sv
module pk_lane
  import pk_pkg::*;
#(
  parameter int W   = 8,
  parameter bit SGN = 1'b0
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int XW = W + 2;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic [XW-1:0] widen(input logic [W-1:0] v);
    if (SGN) return {{2{v[W-1]}}, v};
    else     return {2'b00, v};
  endfunction

  function automatic logic [W-1:0] clamp_signed(input logic a_neg);
    return a_neg ? SMIN : SMAX;
  endfunction

  logic [XW-1:0] ax, bx, sum_x, dif_x, half_x;
  logic          add_over, sub_over, rnd;

  always_comb begin
    ax    = widen(a);
    bx    = widen(b);
    sum_x = ax + bx;
    dif_x = ax - bx;
    if (SGN) begin
      add_over = sum_x[W] ^ sum_x[W-1];
      sub_over = dif_x[W] ^ dif_x[W-1];
    end else begin
      add_over = sum_x[W];
      sub_over = dif_x[XW-1];
    end
  end

  always_comb begin
    rnd    = (op == OP_HADDR) || (op == OP_HSUBR);
    half_x = ((op == OP_HADD) || (op == OP_HADDR)) ? sum_x : dif_x;
    half_x = half_x + {{(XW-1){1'b0}}, rnd};
  end

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (op)
      OP_ADD: begin
        res = sum_x[W-1:0];
        ovf = add_over;
      end
      OP_SUB: begin
        res = dif_x[W-1:0];
        ovf = sub_over;
      end
      OP_ADDS: begin
        ovf = add_over;
        if (!add_over)  res = sum_x[W-1:0];
        else if (SGN)   res = clamp_signed(a[W-1]);
        else            res = '1;
      end
      OP_SUBS: begin
        ovf = sub_over;
        if (!sub_over)  res = dif_x[W-1:0];
        else if (SGN)   res = clamp_signed(a[W-1]);
        else            res = '0;
      end
      OP_ABS: begin
        if (a == SMIN) begin
          res = SMAX;
          ovf = 1'b1;
        end else begin
          res = a[W-1] ? (~a + 1'b1) : a;
        end
      end
      OP_HADD, OP_HADDR, OP_HSUB, OP_HSUBR: begin
        res = half_x[W:1];
      end
      default: begin
        res = '0;
        ovf = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pk_lane_bank.sv
module pk_lane_bank #(
  parameter int DATA_W = 32,
  parameter int W      = 8,
  parameter bit SGN    = 1'b0
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              any_ovf
);
  localparam int NL = DATA_W / W;

  logic [NL-1:0] lane_ovf;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    pk_lane #(.W(W), .SGN(SGN)) u_lane (
      .op  (op),
      .a   (a[i*W +: W]),
      .b   (b[i*W +: W]),
      .res (res[i*W +: W]),
      .ovf (lane_ovf[i])
    );
  end

  assign any_ovf = |lane_ovf;

endmodule

// File: rtl/pk_addsub_unit.sv
module pk_addsub_unit
  import pk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [CTL_W-1:0]  ctl_img
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  logic [DATA_W-1:0] res_u8, res_s16, res_s32;
  logic              ovf_u8, ovf_s16, ovf_s32;

  // Named events used by the bound checker
  logic [DATA_W-1:0] sel_res;
  logic              sel_ovf;
  logic              sticky_q;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;

  pk_lane_bank #(.DATA_W(DATA_W), .W(BYTE_W), .SGN(1'b0)) u_bank_u8 (
    .op(op), .a(opa), .b(opb), .res(res_u8), .any_ovf(ovf_u8));

  pk_lane_bank #(.DATA_W(DATA_W), .W(HALF_W), .SGN(1'b1)) u_bank_s16 (
    .op(op), .a(opa), .b(opb), .res(res_s16), .any_ovf(ovf_s16));

  pk_lane_bank #(.DATA_W(DATA_W), .W(WORD_W), .SGN(1'b1)) u_bank_s32 (
    .op(op), .a(opa), .b(opb), .res(res_s32), .any_ovf(ovf_s32));

  always_comb begin
    case (lane_mode_e'(mode))
      LM_U8:   begin sel_res = res_u8;  sel_ovf = ovf_u8;  end
      LM_S16:  begin sel_res = res_s16; sel_ovf = ovf_s16; end
      LM_S32:  begin sel_res = res_s32; sel_ovf = ovf_s32; end
      default: begin sel_res = '0;      sel_ovf = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      res_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q <= sel_res;
        if (sel_ovf) sticky_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl_img          = '0;
    ctl_img[OVF_BIT] = sticky_q;
  end

  assign out_valid = valid_q;
  assign result    = res_q;

endmodule

// File: rtl/pk_addsub_chk.sv
module pk_addsub_chk #(
  parameter int DATA_W  = 32,
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] opa,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [CTL_W-1:0]  ctl_img,
  input logic              sel_ovf
);
  localparam logic [CTL_W-1:0]  FLAG_MASK = CTL_W'(1) << OVF_BIT;
  localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ctl_img) && !out_valid));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_img[OVF_BIT] |=> ctl_img[OVF_BIT]);

  assert_flag_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_ovf) |=> ctl_img[OVF_BIT]);

  assert_other_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_img & ~FLAG_MASK) == '0);

  assert_halving_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op >= 4'd5) && (op <= 4'd8)) |-> !sel_ovf);

  assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op > 4'd8)) |=> (result == '0));

  assert_abs_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && op == 4'd4 && opa == WMIN) |=> (result == WMAX));

  assert_reserved_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (result == '0));

endmodule

bind pk_addsub_unit pk_addsub_chk #(
  .DATA_W(DATA_W), .CTL_W(CTL_W), .OVF_BIT(OVF_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .op(op),
  .opa(opa), .out_valid(out_valid), .result(result), .ctl_img(ctl_img),
  .sel_ovf(sel_ovf)
);

// File: tb/tb_pk_addsub_unit.sv
module tb_pk_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [31:0] result, ctl_img;

  int checks = 0;
  int errors = 0;
  bit exp_sticky = 1'b0;

  pk_addsub_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .ctl_img(ctl_img));

  always #4 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural lane model in plain integer arithmetic
  function automatic longint lane_model(input int w, input bit sgn, input int code,
                                        input longint ua, input longint ub, output bit ov);
    longint span = longint'(1) << w;
    longint m    = span - 1;
    longint smax = (longint'(1) << (w - 1)) - 1;
    longint smin = -smax - 1;
    longint sa   = ((ua >> (w - 1)) & 1) != 0 ? ua - span : ua;
    longint sb   = ((ub >> (w - 1)) & 1) != 0 ? ub - span : ub;
    longint va   = sgn ? sa : ua;
    longint vb   = sgn ? sb : ub;
    longint r;
    ov = 1'b0;
    case (code)
      0, 2: begin
        r  = va + vb;
        ov = sgn ? (r > smax || r < smin) : (r > m);
        if (code == 2 && ov) r = sgn ? (r > smax ? smax : smin) : m;
      end
      1, 3: begin
        r  = va - vb;
        ov = sgn ? (r > smax || r < smin) : (r < 0);
        if (code == 3 && ov) r = sgn ? (r > smax ? smax : smin) : 0;
      end
      4: begin
        if (sa == smin) begin r = smax; ov = 1'b1; end
        else r = sa < 0 ? -sa : sa;
      end
      5: r = (va + vb) >>> 1;
      6: r = (va + vb + 1) >>> 1;
      7: r = (va - vb) >>> 1;
      8: r = (va - vb + 1) >>> 1;
      default: r = 0;
    endcase
    return r & m;
  endfunction

  function automatic logic [31:0] word_model(input int md, input int code,
                                             input logic [31:0] a, input logic [31:0] b,
                                             output bit ov);
    logic [31:0] acc = '0;
    int w;
    bit sg;
    bit lov;
    ov = 1'b0;
    if (md == 3) return '0;
    w  = (md == 0) ? 8 : (md == 1) ? 16 : 32;
    sg = (md != 0);
    for (int i = 0; i < 32 / w; i++) begin
      longint la = (longint'(a) >> (i * w)) & ((longint'(1) << w) - 1);
      longint lb = (longint'(b) >> (i * w)) & ((longint'(1) << w) - 1);
      longint lr = lane_model(w, sg, code, la, lb, lov);
      acc = acc | (32'(lr) << (i * w));
      ov = ov | lov;
    end
    return acc;
  endfunction

  function automatic longint edge_val(input int w, input int k);
    longint m = (longint'(1) << w) - 1;
    case (k % 8)
      0: return 0;
      1: return 1;
      2: return (longint'(1) << (w - 1)) - 1;
      3: return longint'(1) << (w - 1);
      4: return m;
      5: return m - 1;
      6: return longint'(1) << (w - 2);
      default: return (longint'(1) << (w - 1)) + 1;
    endcase
  endfunction

  function automatic string req_of(input int md, input int code);
    if (md == 3) return "R1";
    if (code > 8) return "R9";
    if (code <= 1) return "R2";
    if (code <= 3) return (md == 0) ? "R4" : "R3";
    if (code == 4) return "R5";
    return "R6";
  endfunction

  task automatic run_op(input int md, input int code, input logic [31:0] a, input logic [31:0] b);
    bit ov;
    logic [31:0] exp;
    exp = word_model(md, code, a, b, ov);
    @(negedge clk);
    in_valid = 1'b1; mode = 2'(md); op = 4'(code); opa = a; opb = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    exp_sticky = exp_sticky | ov;
    check(req_of(md, code), "result", result, exp);
    check("R8", "control image", ctl_img, exp_sticky ? 32'h0010_0000 : 32'h0);
    check("R7", "out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  task automatic sweep(input int md, input int code);
    int w = (md == 0) ? 8 : (md == 1) ? 16 : 32;
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        logic [31:0] a = '0, b = '0;
        for (int l = 0; l < 32 / w; l++) begin
          a = a | (32'(edge_val(w, ia + l)) << (l * w));
          b = b | (32'(edge_val(w, ib + 3 * l)) << (l * w));
        end
        run_op(md, code, a, b);
      end
    end
    for (int r = 0; r < 40; r++) run_op(md, code, $urandom, $urandom);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    exp_sticky = 1'b0;
    @(negedge clk);
    check("R10", "result after reset", result, 32'h0);
    check("R10", "control after reset", ctl_img, 32'h0);
    check("R10", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] held;
    do_reset();

    // R7: an overflowing operation presented without the strobe is ignored
    @(negedge clk);
    in_valid = 1'b0; mode = 2'd2; op = 4'd0; opa = 32'h7FFF_FFFF; opb = 32'h1;
    @(posedge clk); #1;
    check("R7", "result idle", result, 32'h0);
    check("R7", "control idle", ctl_img, 32'h0);

    // Non-flagging functions first, so the control image must stay zero (R6, R1, R9)
    for (int md = 0; md < 3; md++)
      for (int code = 5; code <= 8; code++) sweep(md, code);
    for (int code = 0; code < 9; code++) run_op(3, code, 32'h7FFF_FFFF, 32'h8000_0001);
    for (int code = 9; code < 16; code++) begin
      run_op(0, code, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op(2, code, 32'h8000_0000, 32'h7FFF_FFFF);
    end
    check("R6", "control after quiet ops", ctl_img, 32'h0);

    // Directed corner: 0 - min in a 16-bit lane saturates high (R3)
    run_op(1, 3, 32'h0000_0000, 32'h8000_8000);
    check("R3", "zero minus min", result, 32'h7FFF_7FFF);

    for (int md = 0; md < 3; md++)
      for (int code = 0; code <= 4; code++) sweep(md, code);

    // R7: hold while idle with new operands on the pins
    held = result;
    @(negedge clk);
    in_valid = 1'b0; opa = ~opa; opb = ~opb;
    @(posedge clk); #1;
    check("R7", "result hold", result, held);
    check("R7", "out_valid idle", {31'b0, out_valid}, 32'h0);

    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule